// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models a word-wide parallel NOR flash device with a small on-chip array. A host drives it over a synchronous bus: a word address, write data, a one-cycle write strobe, a one-cycle read strobe, and a registered read-data word. Writes are not stored directly. They are fed to a keyed command interpreter. Software must first present a two-write unlock key. Only then is a command byte accepted, and that command starts a program or erase, switches to an identification or geometry table, or enters a fast-program mode that no longer needs the key.

Programming can only clear bits. An erase, sector-wide or whole-array, sets every word it covers back to all ones. While a program or erase is running, any read returns a status word in place of data. A host polls that word until two reads in a row agree. The length of the busy window is set by a parameter counted in clock cycles, and writes that arrive during that window are dropped.

Top module: `nor_flash_model`

## Requirements
- R1: After a synchronous active-low reset, rdata is 0, the device is in array-read mode, no command sequence is pending and it is not busy.
- R2: A command is accepted only after the key pair: data 0xAA at word address 0x555, then data 0x55 at word address 0x2AA. Only the low byte of wdata forms the command code. The command byte itself must go to 0x555, with codes 0xA0 program, 0x80 erase setup, 0x90 identify, 0x20 enter fast-program mode.
- R3: The key pair, then 0xA0 at 0x555, then a data write at a target address makes the stored word equal to the old contents AND the written data. Programming 0x55 and then 0xA5 into an erased word leaves 0x0005.
- R4: The key pair, 0x80 at 0x555, and the key pair again open an erase. Then 0x30 at any address erases only the sector that holds the address (SECTOR_W low word-address bits select the word within a sector), while 0x10 at 0x555 erases the whole array. Erased words read 0xFFFF.
- R5: While busy, a read returns a status word. In it, bit 7 is 0 during an erase and the inverse of the programmed data's bit 7 during a program. Bit 6 inverts on each successive read. All other bits are 0. After completion, repeated reads return identical array data.
- R6: A program keeps the device busy for BUSY_CYCLES cycles. An erase keeps it busy for the number of words erased plus BUSY_CYCLES. Writes that arrive while busy are ignored and leave no partial sequence behind.
- R7: The key pair and then 0x90 at 0x555 enter identify mode. In this mode offset 0 reads 0x00BF, offset 1 reads 0x236D and other offsets read 0. Any write, such as 0xF0, returns the device to array-read mode.
- R8: 0x98 written at 0x55 in array-read mode enters geometry mode. Offsets 0x10, 0x11 and 0x12 then read 0x51, 0x52 and 0x59. Offset 0x2C reads 1. Offsets 0x2D and 0x2E give the sector count minus one, low byte first, and offsets 0x2F and 0x30 give the sector byte size divided by 256, low byte first. With the defaults these read 3, 0, 2 and 0. Any write returns the device to array-read mode.
- R9: The key pair and then 0x20 at 0x555 enter fast-program mode. In it, 0xA0 at any address followed by a data write programs without a key. 0x00 leaves the mode, and a later 0xA0 plus data without the key changes nothing.
- R10: A write that does not match the expected next step of a sequence aborts it and returns the device to array-read mode (in fast-program mode such writes are ignored).
- R11: Command address matching uses only the low 11 bits of addr, so a key at 0x5555 and 0x2AAA followed by a command at 0x5555 acts like one at 0x555, 0x2AA and 0x555.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | BUS_AW | Word address for reads and writes |
| wdata | input | DATA_W | Write data; low byte is the command code |
| we | input | 1 | Write strobe, one cycle per write |
| re | input | 1 | Read strobe; rdata updates on the same edge |
| rdata | output | DATA_W | Registered read data, status word while busy |

## Verification
The assertions check every cycle that the busy counter only counts down while it is non-zero. This shows that no write during a busy window can restart or extend an operation. They also check that the command sequencer is idle whenever the device is busy, that the toggle bit flips exactly on reads taken while busy, and that erase status keeps bit 7 low with all unused bits clear. What the stored words hold after a program, a sector or chip erase, a fast-program session, or an aborted key can only be seen through the directed scenarios. The same holds for the identify and geometry table contents and for matching that ignores the high address bits. Each scenario reads those values back at the ports.

// File: rtl/nor_pkg.sv
// Shared types and command codes for the NOR flash command interpreter.
// Assumes a word-addressed bus; command codes are compared on the low byte.
package nor_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_CMD,
        SQ_EKEY0,
        SQ_EKEY1,
        SQ_ECMD,
        SQ_DATA
    } seq_t;

    typedef enum logic [1:0] {
        MD_ARRAY,
        MD_IDENT,
        MD_GEOM,
        MD_FAST
    } mode_t;

    localparam logic [7:0] CODE_KEY0       = 8'hAA;
    localparam logic [7:0] CODE_KEY1       = 8'h55;
    localparam logic [7:0] CODE_PROG       = 8'hA0;
    localparam logic [7:0] CODE_ERASE_SET  = 8'h80;
    localparam logic [7:0] CODE_ERASE_SECT = 8'h30;
    localparam logic [7:0] CODE_ERASE_ALL  = 8'h10;
    localparam logic [7:0] CODE_IDENT      = 8'h90;
    localparam logic [7:0] CODE_GEOM       = 8'h98;
    localparam logic [7:0] CODE_FAST_IN    = 8'h20;
    localparam logic [7:0] CODE_FAST_OUT   = 8'h00;

    localparam logic [15:0] LOC_KEY0 = 16'h0555;
    localparam logic [15:0] LOC_KEY1 = 16'h02AA;
    localparam logic [15:0] LOC_GEOM = 16'h0055;

endpackage

// File: rtl/nor_seq_decoder.sv
// Keyed command sequencer. It tracks the multi-write key/command sequence and
// the persistent read mode, and it issues one-cycle program and erase starts.
// Assumes wr_en is already gated off while an operation is busy.
module nor_seq_decoder
    import nor_pkg::*;
#(
    parameter int BUS_AW = 16,
    parameter int CMD_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] addr,
    input  logic [7:0]        cmd,
    output mode_t             mode,
    output logic              seq_idle,
    output logic              prog_go,
    output logic              erase_go,
    output logic              erase_all
);
    localparam logic [BUS_AW-1:0] CMD_MASK = BUS_AW'((64'd1 << CMD_AW) - 64'd1);

    seq_t  seq_q, seq_n;
    mode_t mode_q, mode_n;
    logic  at_key0, at_key1, at_geom;
    logic  [BUS_AW-1:0] cmd_addr;

    // Match command addresses on the low CMD_AW bits only.
    always_comb begin
        cmd_addr = addr & CMD_MASK;
        at_key0  = (cmd_addr == BUS_AW'(LOC_KEY0));
        at_key1  = (cmd_addr == BUS_AW'(LOC_KEY1));
        at_geom  = (cmd_addr == BUS_AW'(LOC_GEOM));
    end

    // Next sequence step and mode for each accepted write.
    always_comb begin
        seq_n     = seq_q;
        mode_n    = mode_q;
        prog_go   = 1'b0;
        erase_go  = 1'b0;
        erase_all = 1'b0;
        if (wr_en) begin
            seq_n = SQ_IDLE;
            unique case (seq_q)
                SQ_IDLE: begin
                    unique case (mode_q)
                        MD_FAST: begin
                            if (cmd == CODE_PROG)
                                seq_n = SQ_DATA;
                            else if (cmd == CODE_FAST_OUT)
                                mode_n = MD_ARRAY;
                        end
                        MD_IDENT, MD_GEOM: mode_n = MD_ARRAY;
                        default: begin
                            if (cmd == CODE_KEY0 && at_key0)
                                seq_n = SQ_KEY1;
                            else if (cmd == CODE_GEOM && at_geom)
                                mode_n = MD_GEOM;
                        end
                    endcase
                end
                SQ_KEY1: if (cmd == CODE_KEY1 && at_key1) seq_n = SQ_CMD;
                SQ_CMD: begin
                    if (at_key0) begin
                        if (cmd == CODE_PROG)
                            seq_n = SQ_DATA;
                        else if (cmd == CODE_ERASE_SET)
                            seq_n = SQ_EKEY0;
                        else if (cmd == CODE_IDENT)
                            mode_n = MD_IDENT;
                        else if (cmd == CODE_FAST_IN)
                            mode_n = MD_FAST;
                    end
                end
                SQ_EKEY0: if (cmd == CODE_KEY0 && at_key0) seq_n = SQ_EKEY1;
                SQ_EKEY1: if (cmd == CODE_KEY1 && at_key1) seq_n = SQ_ECMD;
                SQ_ECMD: begin
                    if (cmd == CODE_ERASE_SECT) begin
                        erase_go = 1'b1;
                    end else if (cmd == CODE_ERASE_ALL && at_key0) begin
                        erase_go  = 1'b1;
                        erase_all = 1'b1;
                    end
                end
                SQ_DATA: prog_go = 1'b1;
                default: seq_n = SQ_IDLE;
            endcase
        end
    end

    // Sequence and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= SQ_IDLE;
            mode_q <= MD_ARRAY;
        end else begin
            seq_q  <= seq_n;
            mode_q <= mode_n;
        end
    end

    assign mode     = mode_q;
    assign seq_idle = (seq_q == SQ_IDLE);

endmodule

// File: rtl/nor_busy_ctrl.sv
// Busy timer, erase sweep and status word. An erase writes ones one word per
// cycle from the start of its range; the busy window covers the sweep plus
// BUSY_CYCLES. Assumes ADDR_W > SECTOR_W and BUSY_CYCLES >= 1.
module nor_busy_ctrl #(
    parameter int ADDR_W      = 10,
    parameter int SECTOR_W    = 8,
    parameter int DATA_W      = 16,
    parameter int BUSY_CYCLES = 8,
    localparam int WORDS        = 1 << ADDR_W,
    localparam int SECTOR_WORDS = 1 << SECTOR_W,
    localparam int CNT_W        = $clog2(WORDS + BUSY_CYCLES + 1),
    localparam int LEFT_W       = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_go,
    input  logic              erase_go,
    input  logic              erase_all,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic              prog_bit7,
    input  logic              rd_en,
    output logic              busy,
    output logic [CNT_W-1:0]  cnt,
    output logic              tgl,
    output logic              op_erase,
    output logic              sweep_we,
    output logic [ADDR_W-1:0] sweep_addr,
    output logic [DATA_W-1:0] status
);
    localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'(SECTOR_WORDS - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [LEFT_W-1:0] left_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              erase_q, dq7_q, tgl_q;
    logic [ADDR_W-1:0] sect_base;

    assign sect_base = word_addr & ~SECT_MASK;

    // Operation start, countdown and erase sweep pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            left_q  <= '0;
            ptr_q   <= '0;
            erase_q <= 1'b0;
            dq7_q   <= 1'b0;
        end else if (erase_go) begin
            erase_q <= 1'b1;
            cnt_q   <= erase_all ? CNT_W'(WORDS + BUSY_CYCLES)
                                 : CNT_W'(SECTOR_WORDS + BUSY_CYCLES);
            left_q  <= erase_all ? LEFT_W'(WORDS) : LEFT_W'(SECTOR_WORDS);
            ptr_q   <= erase_all ? '0 : sect_base;
        end else if (prog_go) begin
            erase_q <= 1'b0;
            dq7_q   <= ~prog_bit7;
            cnt_q   <= CNT_W'(BUSY_CYCLES);
        end else begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            if (left_q != '0) begin
                left_q <= left_q - 1'b1;
                ptr_q  <= ptr_q + 1'b1;
            end
        end
    end

    // Toggle bit flips on every read taken while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tgl_q <= 1'b0;
        else if (rd_en && busy)
            tgl_q <= ~tgl_q;
    end

    // Status word presented to the read path.
    always_comb begin
        status    = '0;
        status[7] = erase_q ? 1'b0 : dq7_q;
        status[6] = tgl_q;
    end

    assign busy       = (cnt_q != '0);
    assign cnt        = cnt_q;
    assign tgl        = tgl_q;
    assign op_erase   = erase_q;
    assign sweep_we   = (left_q != '0);
    assign sweep_addr = ptr_q;

endmodule

// File: rtl/nor_id_rom.sv
// Identification and geometry table. The geometry entries are derived from
// the array parameters. Assumes DATA_W >= 16.
module nor_id_rom #(
    parameter int ADDR_W   = 10,
    parameter int SECTOR_W = 8,
    parameter int DATA_W   = 16,
    localparam int SECTORS    = 1 << (ADDR_W - SECTOR_W),
    localparam int SECT_UNITS = ((1 << SECTOR_W) * (DATA_W / 8)) / 256
) (
    input  logic [7:0]        offset,
    input  logic              ident,
    output logic [DATA_W-1:0] data
);
    // Table lookup by offset for the selected table.
    always_comb begin
        data = '0;
        if (ident) begin
            if (offset == 8'h00) data = DATA_W'(16'h00BF);
            else if (offset == 8'h01) data = DATA_W'(16'h236D);
        end else begin
            case (offset)
                8'h10: data = DATA_W'(8'h51);
                8'h11: data = DATA_W'(8'h52);
                8'h12: data = DATA_W'(8'h59);
                8'h2C: data = DATA_W'(1);
                8'h2D: data = DATA_W'((SECTORS - 1) & 255);
                8'h2E: data = DATA_W'(((SECTORS - 1) >> 8) & 255);
                8'h2F: data = DATA_W'(SECT_UNITS & 255);
                8'h30: data = DATA_W'((SECT_UNITS >> 8) & 255);
                default: data = '0;
            endcase
        end
    end

endmodule

// File: rtl/nor_array.sv
// Storage array with one write port that either sets a word to ones (erase)
// or ANDs the data into it (program), and a combinational read port.
// Contents are undefined after power-up until erased.
module nor_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic              set_ones,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    // Program clears bits only; erase restores all ones.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= set_ones ? {DATA_W{1'b1}} : (mem[waddr] & wdata);
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/nor_flash_model.sv
// Parallel NOR flash command interpreter: keyed command decode, AND-only
// programming, sector and chip erase, identify and geometry tables, and a
// keyless fast-program mode. Reads are registered; while busy they return
// the status word. Assumes one-cycle we/re strobes.
module nor_flash_model
    import nor_pkg::*;
#(
    parameter int BUS_AW      = 16,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 10,
    parameter int SECTOR_W    = 8,
    parameter int CMD_AW      = 11,
    parameter int BUSY_CYCLES = 8,
    localparam int WORDS = 1 << ADDR_W,
    localparam int CNT_W = $clog2(WORDS + BUSY_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    output logic [DATA_W-1:0] rdata
);
    mode_t             mode_w;
    logic              seq_idle_w, prog_go, erase_go, erase_all;
    logic              busy_w, tgl_w, op_erase_w, sweep_we;
    logic [CNT_W-1:0]  cnt_w;
    logic [ADDR_W-1:0] sweep_addr, mem_waddr, word_addr;
    logic [DATA_W-1:0] status_w, arr_data, rom_data;
    logic              wr_en;

    assign wr_en     = we && !busy_w;
    assign word_addr = addr[ADDR_W-1:0];
    assign mem_waddr = sweep_we ? sweep_addr : word_addr;

    nor_seq_decoder #(.BUS_AW(BUS_AW), .CMD_AW(CMD_AW)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .cmd(wdata[7:0]), .mode(mode_w), .seq_idle(seq_idle_w),
        .prog_go(prog_go), .erase_go(erase_go), .erase_all(erase_all)
    );

    nor_busy_ctrl #(
        .ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .DATA_W(DATA_W),
        .BUSY_CYCLES(BUSY_CYCLES)
    ) u_busy (
        .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go),
        .erase_all(erase_all), .word_addr(word_addr), .prog_bit7(wdata[7]),
        .rd_en(re), .busy(busy_w), .cnt(cnt_w), .tgl(tgl_w),
        .op_erase(op_erase_w), .sweep_we(sweep_we), .sweep_addr(sweep_addr),
        .status(status_w)
    );

    nor_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .we(prog_go | sweep_we), .set_ones(sweep_we),
        .waddr(mem_waddr), .wdata(wdata), .raddr(word_addr), .rdata(arr_data)
    );

    nor_id_rom #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .DATA_W(DATA_W)) u_rom (
        .offset(addr[7:0]), .ident(mode_w == MD_IDENT), .data(rom_data)
    );

    // Registered read path: status while busy, else table or array data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (re) begin
            if (busy_w)
                rdata <= status_w;
            else if (mode_w == MD_IDENT || mode_w == MD_GEOM)
                rdata <= rom_data;
            else
                rdata <= arr_data;
        end
    end

endmodule

// File: rtl/nor_flash_checker.sv
// Cycle-level properties of the flash model, attached by bind below.
module nor_flash_checker #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              re,
    input logic [DATA_W-1:0] rdata,
    input logic              busy,
    input logic [CNT_W-1:0]  cnt,
    input logic              tgl,
    input logic              op_erase,
    input logic              seq_idle
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0 && !busy && seq_idle));

    // R6
    busy_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R10
    idle_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> seq_idle);

    // R5
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && busy) |=> (tgl != $past(tgl)));

    // R5
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(re && busy) |=> $stable(tgl));

    // R5
    erase_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && busy && op_erase) |=> (rdata[7] == 1'b0 && rdata[5:0] == '0
                                      && rdata[DATA_W-1:8] == '0));
endmodule

bind nor_flash_model nor_flash_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .re(re), .rdata(rdata), .busy(busy_w),
    .cnt(cnt_w), .tgl(tgl_w), .op_erase(op_erase_w), .seq_idle(seq_idle_w)
);

// File: tb/tb_nor_flash_model.sv
// Directed bench: one task per scenario, each checking its own read-backs.
module tb_nor_flash_model;
    localparam int BUSY_CYCLES = 8;
    localparam int ADDR_W = 10;
    localparam int SECTOR_W = 8;
    localparam int POLL_MAX = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [15:0] rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    nor_flash_model #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W),
                      .BUSY_CYCLES(BUSY_CYCLES)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .we(we), .re(re), .rdata(rdata)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [15:0] d);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic key();
        bus_wr(16'h0555, 16'h00AA);
        bus_wr(16'h02AA, 16'h0055);
    endtask

    task automatic wait_ready(input string req, input logic [15:0] a);
        logic [15:0] r1, r2;
        bit ok = 1'b0;
        for (int i = 0; i < POLL_MAX && !ok; i++) begin
            bus_rd(a, r1);
            bus_rd(a, r2);
            if (r1 === r2) ok = 1'b1;
        end
        check(req, 16'(ok), 16'd1);
    endtask

    task automatic program_word(input logic [15:0] a, input logic [15:0] d);
        key();
        bus_wr(16'h0555, 16'h00A0);
        bus_wr(a, d);
        wait_ready("R6 program completes", a);
    endtask

    task automatic t_reset();
        check("R1 rdata after reset", rdata, 16'h0000);
    endtask

    task automatic t_chip_erase();
        logic [15:0] s1, s2, v;
        key();
        bus_wr(16'h0555, 16'h0080);
        key();
        bus_wr(16'h0555, 16'h0010);
        bus_rd(16'h0000, s1);
        bus_rd(16'h0000, s2);
        check("R5 erase status bit7", s1 & 16'h0080, 16'h0000);
        check("R5 erase status bit6 toggles", (s1 ^ s2) & 16'h0040, 16'h0040);
        check("R5 status unused bits", s1 & 16'hFF3F, 16'h0000);
        wait_ready("R5 erase completes", 16'h0000);
        bus_rd(16'h0000, v);
        check("R4 chip erase first word", v, 16'hFFFF);
        bus_rd(16'h03FF, v);
        check("R4 chip erase last word", v, 16'hFFFF);
        bus_rd(16'h0155, v);
        check("R4 chip erase middle word", v, 16'hFFFF);
    endtask

    task automatic t_program();
        logic [15:0] s, v;
        key();
        bus_wr(16'h0555, 16'h00A0);
        bus_wr(16'h0010, 16'h0055);
        bus_rd(16'h0010, s);
        check("R5 program status bit7", s & 16'h0080, 16'h0080);
        wait_ready("R6 program completes", 16'h0010);
        bus_rd(16'h0010, v);
        check("R3 first program", v, 16'h0055);
        program_word(16'h0010, 16'h00A5);
        bus_rd(16'h0010, v);
        check("R3 AND with old contents", v, 16'h0005);
    endtask

    task automatic t_key_required();
        logic [15:0] v;
        bus_wr(16'h02AA, 16'h0055);
        bus_wr(16'h0555, 16'h00A0);
        bus_wr(16'h0011, 16'h0000);
        bus_rd(16'h0011, v);
        check("R2 program without key ignored", v, 16'hFFFF);
        key();
        bus_wr(16'h0123, 16'h00A0);
        bus_wr(16'h0012, 16'h0000);
        bus_rd(16'h0012, v);
        check("R2 command off 0x555 ignored", v, 16'hFFFF);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] v;
        key();
        bus_wr(16'h0555, 16'h00A0);
        bus_wr(16'h0020, 16'h1234);
        key();
        bus_wr(16'h0555, 16'h00A0);
        bus_wr(16'h0021, 16'h0000);
        wait_ready("R6 program completes", 16'h0020);
        bus_rd(16'h0020, v);
        check("R3 programmed word", v, 16'h1234);
        bus_rd(16'h0021, v);
        check("R6 writes while busy ignored", v, 16'hFFFF);
        bus_wr(16'h0021, 16'h0000);
        bus_rd(16'h0021, v);
        check("R6 no sequence left pending", v, 16'hFFFF);
    endtask

    task automatic t_sector_erase();
        logic [15:0] v;
        program_word(16'h0100, 16'h00FF);
        program_word(16'h01FF, 16'h0F0F);
        program_word(16'h0200, 16'hBEEF);
        key();
        bus_wr(16'h0555, 16'h0080);
        key();
        bus_wr(16'h01AB, 16'h0030);
        wait_ready("R4 sector erase completes", 16'h0100);
        bus_rd(16'h0100, v);
        check("R4 sector start erased", v, 16'hFFFF);
        bus_rd(16'h01FF, v);
        check("R4 sector end erased", v, 16'hFFFF);
        bus_rd(16'h0200, v);
        check("R4 next sector kept", v, 16'hBEEF);
        bus_rd(16'h0010, v);
        check("R4 sector 0 kept", v, 16'h0005);
    endtask

    task automatic t_ident();
        logic [15:0] v;
        key();
        bus_wr(16'h0555, 16'h0090);
        bus_rd(16'h0000, v);
        check("R7 maker id", v, 16'h00BF);
        bus_rd(16'h0001, v);
        check("R7 device id", v, 16'h236D);
        bus_rd(16'h0005, v);
        check("R7 other offset", v, 16'h0000);
        bus_wr(16'h0000, 16'h00F0);
        bus_rd(16'h0010, v);
        check("R7 back to array", v, 16'h0005);
    endtask

    task automatic t_geometry();
        logic [15:0] v;
        bus_wr(16'h0055, 16'h0098);
        bus_rd(16'h0010, v); check("R8 Q", v, 16'h0051);
        bus_rd(16'h0011, v); check("R8 R", v, 16'h0052);
        bus_rd(16'h0012, v); check("R8 Y", v, 16'h0059);
        bus_rd(16'h002C, v); check("R8 regions", v, 16'h0001);
        bus_rd(16'h002D, v); check("R8 sectors-1 low", v, 16'(((1 << (ADDR_W - SECTOR_W)) - 1) & 255));
        bus_rd(16'h002E, v); check("R8 sectors-1 high", v, 16'h0000);
        bus_rd(16'h002F, v); check("R8 size low", v, 16'(((1 << SECTOR_W) * 2 / 256) & 255));
        bus_rd(16'h0030, v); check("R8 size high", v, 16'h0000);
        bus_wr(16'h0000, 16'h00F0);
        bus_rd(16'h0020, v);
        check("R8 back to array", v, 16'h1234);
    endtask

    task automatic t_fast();
        logic [15:0] v;
        key();
        bus_wr(16'h0555, 16'h0020);
        bus_wr(16'h0123, 16'h00A0);
        bus_wr(16'h0030, 16'h0123);
        wait_ready("R9 fast program completes", 16'h0030);
        bus_wr(16'h0777, 16'h00A0);
        bus_wr(16'h0031, 16'h4567);
        wait_ready("R9 fast program completes", 16'h0031);
        bus_wr(16'h0000, 16'h0000);
        bus_wr(16'h0555, 16'h00A0);
        bus_wr(16'h0032, 16'h89AB);
        bus_rd(16'h0030, v); check("R9 fast word 0", v, 16'h0123);
        bus_rd(16'h0031, v); check("R9 fast word any address", v, 16'h4567);
        bus_rd(16'h0032, v); check("R9 after exit ignored", v, 16'hFFFF);
    endtask

    task automatic t_abort();
        logic [15:0] v;
        bus_wr(16'h0555, 16'h00AA);
        bus_wr(16'h02AA, 16'h0077);
        bus_wr(16'h0555, 16'h00A0);
        bus_wr(16'h0040, 16'h0000);
        bus_rd(16'h0040, v);
        check("R10 bad key aborts", v, 16'hFFFF);
        key();
        bus_wr(16'h0555, 16'h0090);
        bus_wr(16'h0333, 16'h0012);
        bus_rd(16'h0000, v);
        check("R10 stray write leaves identify", v, 16'hFFFF);
    endtask

    task automatic t_high_addr();
        logic [15:0] v;
        bus_wr(16'h5555, 16'h00AA);
        bus_wr(16'h2AAA, 16'h0055);
        bus_wr(16'h5555, 16'h0090);
        bus_rd(16'h0000, v);
        check("R11 high bits ignored", v, 16'h00BF);
        bus_wr(16'h0000, 16'h00F0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chip_erase();
        t_program();
        t_key_required();
        t_busy_ignore();
        t_sector_erase();
        t_ident();
        t_geometry();
        t_fast();
        t_abort();
        t_high_addr();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule